// File: doc/BRIEF.md
# Widening Even/Odd Vector Add-Subtract Unit

This execution unit serves a 256-bit vector datapath. It receives two 256-bit source vectors and a 17-bit major opcode field. From each source it takes either the even-indexed or the odd-indexed narrow elements at the selected size. It widens each of those elements to twice its width and then adds or subtracts the pair. The 256-bit result is registered and appears one clock after the operation is accepted.

Operands are extended under one of three rules. The signed rule sign-extends both elements. The unsigned rule zero-extends both. The mixed rule applies to add only: it zero-extends the first source element and sign-extends the second. Source elements may be 8, 16, 32 or 64 bits wide. With 64-bit sources the unit forms two full 128-bit results. If the opcode field decodes to no known operation, the unit raises an illegal flag and produces no result.

Top module: `wide_evod_alu`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `out_valid` and `out_illegal` are 0 and `result` is all zeros.
- R2: For signed even add with source width W, result element i (bits [2W·i +: 2W]) equals sext(A element 2i) + sext(B element 2i), taken modulo 2^(2W).
- R3: The odd forms use source elements 2i+1 of both operands in place of 2i.
- R4: The unsigned forms zero-extend both selected elements before the operation.
- R5: The mixed add zero-extends the A element and sign-extends the B element, in both its even and odd forms.
- R6: Subtract forms compute the widened A minus the widened B, modulo 2^(2W).
- R7: With 64-bit sources, 128-bit result element 0 uses doubleword 0 (even) or 1 (odd), and element 1 uses doubleword 2 (even) or 3 (odd).
- R8: `op_field[1:0]` selects the source width (0=8, 1=16, 2=32, 3=64). `op_field[16:2]` selects the operation as follows. Signed: even add 0111_01000001_111, odd add 0111_01000010_001, even sub 0111_01000010_000, odd sub 0111_01000010_010. Unsigned: even add 0111_01000010_111, odd add 0111_01000011_001, even sub 0111_01000011_000, odd sub 0111_01000011_010. Mixed: even add 0111_01000011_111, odd add 0111_01000100_000.
- R9: If `in_valid` is high with any other opcode field, `out_illegal` is 1 and `out_valid` is 0 on the next cycle, and `result` keeps its previous value. The two flags are never high together.
- R10: `in_valid` with a legal opcode raises `out_valid` for exactly the next cycle. A cycle without `in_valid` leaves both flags low on the next cycle and `result` unchanged.
- R11: For every legal operation, all 256 result bits are written. No lane keeps a stale value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_field | input | 17 | Major opcode field (instruction bits 31:15) |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| out_valid | output | 1 | Result register updated by a legal operation |
| out_illegal | output | 1 | Previous accepted opcode was not recognised |
| result | output | 256 | Registered widened result |

## Verification
Two events can coincide in the same cycle: the unit presents the result of one operation while it accepts the next, which may be legal or illegal. The bench provokes this by issuing operations back to back with no gap. Illegal opcodes are placed directly after legal ones. Each flag and each 256-bit value is judged against a queued expectation. For an illegal operation, the expected value is the result that was held before it.

// File: rtl/wide_evod_alu.sv
module wide_evod_alu #(
  parameter int VLEN = 256,
  parameter int OPW  = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op_field,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [VLEN-1:0] result
);
  localparam int NSZ = 4;

  logic legal, odd, sub, sx_a, sx_b;
  logic [1:0] sz;
  assign sz = op_field[1:0];

  always_comb begin
    {legal, odd, sub, sx_a, sx_b} = 5'b0;
    case (op_field[OPW-1:2])
      15'b0111_01000001_111: {legal, odd, sub, sx_a, sx_b} = 5'b10011;
      15'b0111_01000010_001: {legal, odd, sub, sx_a, sx_b} = 5'b11011;
      15'b0111_01000010_000: {legal, odd, sub, sx_a, sx_b} = 5'b10111;
      15'b0111_01000010_010: {legal, odd, sub, sx_a, sx_b} = 5'b11111;
      15'b0111_01000010_111: {legal, odd, sub, sx_a, sx_b} = 5'b10000;
      15'b0111_01000011_001: {legal, odd, sub, sx_a, sx_b} = 5'b11000;
      15'b0111_01000011_000: {legal, odd, sub, sx_a, sx_b} = 5'b10100;
      15'b0111_01000011_010: {legal, odd, sub, sx_a, sx_b} = 5'b11100;
      15'b0111_01000011_111: {legal, odd, sub, sx_a, sx_b} = 5'b10001;
      15'b0111_01000100_000: {legal, odd, sub, sx_a, sx_b} = 5'b11001;
      default:               {legal, odd, sub, sx_a, sx_b} = 5'b00000;
    endcase
  end

  logic [NSZ-1:0][VLEN-1:0] lane_res;

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int W = 8 << g;
    localparam int N = VLEN / (2 * W);
    for (genvar i = 0; i < N; i++) begin : g_el
      logic [W-1:0]   an, bn;
      logic [2*W-1:0] ax, bx;
      assign an = odd ? src_a[(2*i+1)*W +: W] : src_a[2*i*W +: W];
      assign bn = odd ? src_b[(2*i+1)*W +: W] : src_b[2*i*W +: W];
      assign ax = {{W{sx_a & an[W-1]}}, an};
      assign bx = {{W{sx_b & bn[W-1]}}, bn};
      assign lane_res[g][i*2*W +: 2*W] = sub ? ax - bx : ax + bx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result      <= '0;
    end else begin
      out_valid   <= in_valid & legal;
      out_illegal <= in_valid & ~legal;
      if (in_valid && legal) result <= lane_res[sz];
    end
  end
endmodule

module wide_evod_alu_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [VLEN-1:0] result
);
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));
  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> $stable(result));
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid || out_illegal));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

bind wide_evod_alu wide_evod_alu_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_illegal(out_illegal), .result(result)
);

// File: tb/tb_wide_evod_alu.sv
module tb_wide_evod_alu;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [16:0]  op_field = '0;
  logic [255:0] src_a = '0, src_b = '0;
  logic out_valid, out_illegal;
  logic [255:0] result;

  always #4 clk = ~clk;

  wide_evod_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_field(op_field),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .result(result)
  );

  int n_chk = 0, n_bad = 0;
  logic         q_ill[$];
  logic [255:0] q_res[$];
  string        q_tag[$];
  logic [255:0] held = '0;

  localparam logic [14:0] P_SEA = 15'b0111_01000001_111, P_SOA = 15'b0111_01000010_001,
                          P_SES = 15'b0111_01000010_000, P_SOS = 15'b0111_01000010_010,
                          P_UEA = 15'b0111_01000010_111, P_UOA = 15'b0111_01000011_001,
                          P_UES = 15'b0111_01000011_000, P_UOS = 15'b0111_01000011_010,
                          P_MEA = 15'b0111_01000011_111, P_MOA = 15'b0111_01000100_000;

  function automatic logic [14:0] pfx(input int k);
    case (k)
      0: return P_SEA; 1: return P_SOA; 2: return P_SES; 3: return P_SOS;
      4: return P_UEA; 5: return P_UOA; 6: return P_UES; 7: return P_UOS;
      8: return P_MEA; default: return P_MOA;
    endcase
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic model(input logic [16:0] op, input logic [255:0] a, input logic [255:0] b,
                       output logic ill, output logic [255:0] r);
    bit od, sb, sa, sgb;
    int w;
    logic [255:0] mw, m2, ea, eb, s;
    ill = 0; od = 0; sb = 0; sa = 0; sgb = 0;
    case (op[16:2])
      P_SEA: begin sa = 1; sgb = 1; end
      P_SOA: begin od = 1; sa = 1; sgb = 1; end
      P_SES: begin sb = 1; sa = 1; sgb = 1; end
      P_SOS: begin od = 1; sb = 1; sa = 1; sgb = 1; end
      P_UEA: ;
      P_UOA: od = 1;
      P_UES: sb = 1;
      P_UOS: begin od = 1; sb = 1; end
      P_MEA: sgb = 1;
      P_MOA: begin od = 1; sgb = 1; end
      default: ill = 1;
    endcase
    r = held;
    if (ill) return;
    r = '0;
    w = 8 << op[1:0];
    mw = (256'b1 << w) - 1;
    m2 = (256'b1 << (2 * w)) - 1;
    for (int i = 0; i < 256 / (2 * w); i++) begin
      ea = (a >> ((2 * i + int'(od)) * w)) & mw;
      eb = (b >> ((2 * i + int'(od)) * w)) & mw;
      if (sa  && ea[w-1]) ea = ea | (mw << w);
      if (sgb && eb[w-1]) eb = eb | (mw << w);
      s = (sb ? ea - eb : ea + eb) & m2;
      r = r | (s << (i * 2 * w));
    end
  endtask

  task automatic issue(input logic [16:0] op, input logic [255:0] a, input logic [255:0] b,
                       input string tag);
    logic ill;
    logic [255:0] r;
    @(negedge clk);
    model(op, a, b, ill, r);
    if (!ill) held = r;
    in_valid = 1; op_field = op; src_a = a; src_b = b;
    q_ill.push_back(ill); q_res.push_back(r); q_tag.push_back(tag);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    n_chk++;
    if (out_valid || out_illegal || result !== held) begin
      n_bad++;
      $display("FAIL R10 idle: v=%0b ill=%0b res=%h expected flags 0 res=%h",
               out_valid, out_illegal, result, held);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || out_illegal)) begin
      n_chk++;
      if (q_ill.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected output: v=%0b ill=%0b expected none", out_valid, out_illegal);
      end else begin
        automatic logic e_ill = q_ill.pop_front();
        automatic logic [255:0] e_res = q_res.pop_front();
        automatic string t = q_tag.pop_front();
        if (out_illegal !== e_ill || out_valid !== !e_ill || result !== e_res) begin
          n_bad++;
          $display("FAIL %s R8 R11: v=%0b ill=%0b res=%h expected ill=%0b res=%h",
                   t, out_valid, out_illegal, result, e_ill, e_res);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid || out_illegal || result !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: v=%0b ill=%0b res=%h expected 0 0 0", out_valid, out_illegal, result);
    end
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (out_valid || out_illegal || result !== '0) begin
      n_bad++;
      $display("FAIL R1 after release: v=%0b ill=%0b res=%h expected 0 0 0", out_valid, out_illegal, result);
    end

    issue({P_SEA, 2'd0}, {256{1'b1}}, {256{1'b1}}, "R2");
    issue({P_UEA, 2'd0}, {256{1'b1}}, {256{1'b1}}, "R4");
    issue({P_MEA, 2'd0}, {256{1'b1}}, {256{1'b1}}, "R5");
    issue({P_MOA, 2'd2}, {32{8'h80}}, {32{8'hC3}}, "R5");
    issue({P_UES, 2'd0}, '0, {256{1'b1}}, "R6");
    issue({P_SOS, 2'd1}, {16{16'h8000}}, {16{16'h7FFF}}, "R6");
    issue({P_SEA, 2'd3}, {4{64'h8000_0000_0000_0000}}, {4{64'h8000_0000_0000_0000}}, "R7");
    issue({P_UOA, 2'd3}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2},
          {4{64'hFFFF_FFFF_FFFF_FFFF}}, "R7");
    issue({P_MOA, 2'd3}, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'hFFFF_FFFF_FFFF_FFFF}}, "R7");
    issue(17'h0, rnd256(), rnd256(), "R9");
    issue({15'b0111_01000100_001, 2'd0}, rnd256(), rnd256(), "R9");
    issue({P_SOA, 2'd0}, rnd256(), rnd256(), "R3");
    issue({15'b0111_01000001_110, 2'd1}, rnd256(), rnd256(), "R9");
    idle_check();
    idle_check();

    for (int k = 0; k < 10; k++) begin
      for (int s = 0; s < 4; s++) begin
        for (int rep = 0; rep < 3; rep++) begin
          automatic string t = (s == 3) ? "R7" :
                               (k >= 8) ? "R5" :
                               (k == 2 || k == 3 || k == 6 || k == 7) ? "R6" :
                               (k >= 4) ? "R4" : (k == 1) ? "R3" : "R2";
          issue({pfx(k), s[1:0]}, rnd256(), rnd256(), t);
        end
      end
      if (k % 3 == 0) issue({~pfx(k), 2'd0}, rnd256(), rnd256(), "R9");
    end
    idle_check();

    n_chk++;
    if (q_ill.size() != 0) begin
      n_bad++;
      $display("FAIL R10 outstanding: actual %0d expected 0", q_ill.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule